// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. Software enables the block, picks one of eight input channels and a conversion clock, then writes a start bit. The sequencer selects the channel on an analog multiplexer, drives a trial code to an external DAC and reads one comparator bit per conversion period. It works from the most significant bit down to the least significant bit. The start bit reads back as a busy flag, and hardware clears it when the conversion finishes.

When a conversion completes, the block stores the 10-bit code, drops busy, sets a sticky interrupt flag and gives a one-cycle done pulse, all on the same clock edge. The stored code is shown as a 16-bit high/low byte pair, either right- or left-justified. The conversion period is 2, 8 or 32 system clocks, or one pulse of a separate RC-derived clock. That pulse arrives on `rc_tick`, already synchronized to `clk`, and is one cycle wide.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, `busy`, `done`, `irq_flag` and `dac_code` are 0, and the result pair reads 0 in both justifications.
- R2: If `start_wr` is 1 while `enable` is 1 and the block is idle, `busy` is 1 from the next clock edge. `mux_sel` takes the `chan_sel` value present at that edge and holds it for the whole conversion, even if `chan_sel` changes.
- R3: `clksel` 00, 01 and 10 set the conversion period to 2, 8 and 32 system clocks. A conversion keeps `busy` high for exactly 11 periods (one setup period and ten bit periods), so for 22, 88 or 352 cycles.
- R4: With `clksel` = 11, the conversion advances only on cycles where `rc_tick` is 1. `busy` stays high without those pulses and clears on the eleventh pulse.
- R5: Bits are decided MSB first. In each bit period the trial bit is set, and it is kept when `cmp_in` = 1 (input at or above the trial level). Otherwise it is cleared. For a 10-bit input level V, the stored result is V.
- R6: On the completing edge, `busy` falls, the result is stored, `irq_flag` becomes 1 and `done` is high for exactly one cycle.
- R7: With `right_just` = 1, `res_hi` = {6'b0, result[9:8]} and `res_lo` = result[7:0].
- R8: With `right_just` = 0, `res_hi` = result[9:2] and `res_lo` = {result[1:0], 6'b0}.
- R9: A `start_wr` while `enable` = 0 is ignored: `busy` stays 0 and no completion follows.
- R10: Dropping `enable` during a conversion aborts it on the next edge. `busy` clears, the stored result is unchanged, and neither `done` nor `irq_flag` is raised.
- R11: `irq_flag` stays 1 until a cycle with `irq_clr` = 1. A completion on the same edge as `irq_clr` leaves the flag set.
- R12: A `start_wr` during a conversion has no effect; the conversion ends at its original time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module on; 0 shuts off and aborts |
| start_wr | input | 1 | Software write of 1 to the start bit |
| chan_sel | input | 3 | Input channel, 0 to 7 |
| clksel | input | 2 | Conversion clock: 00 /2, 01 /8, 10 /32, 11 RC pulse |
| rc_tick | input | 1 | Synchronized RC-clock pulse |
| right_just | input | 1 | 1 right-justified, 0 left-justified result |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| busy | output | 1 | Start bit readback, 1 during conversion |
| mux_sel | output | 3 | Analog multiplexer channel |
| dac_code | output | 10 | Trial code to the DAC |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |
| done | output | 1 | One-cycle completion pulse |
| irq_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The hardest situations to reach from the ports depend on hitting one exact edge. The first is a software clear of the interrupt flag on the very edge a conversion completes. The second is dropping the enable in the middle of the bit sequence. Latency is fixed at 11 divided periods, so the stimulus counts clock cycles from the start write and places `irq_clr`, a repeated start or the disable on a chosen cycle. The comparator is modelled in the bench from a per-channel level, and every 10-bit level is swept once, so each possible bit decision path through the SAR is covered.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_BITS  = 2'd2
    } sar_phase_e;

    localparam logic [1:0] CKSEL_DIV_A = 2'b00;
    localparam logic [1:0] CKSEL_DIV_B = 2'b01;
    localparam logic [1:0] CKSEL_DIV_C = 2'b10;
    localparam logic [1:0] CKSEL_RC    = 2'b11;

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV_A = 2,
    parameter int DIV_B = 8,
    parameter int DIV_C = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] clksel,
    input  logic       rc_tick,
    output logic       tick
);
    import sar_pkg::*;

    localparam int MAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
    localparam int MAX_D  = (MAX_AB > DIV_C) ? MAX_AB : DIV_C;
    localparam int CNT_W  = (MAX_D > 2) ? $clog2(MAX_D) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;
    logic             use_rc;

    always_comb begin
        use_rc = (clksel == CKSEL_RC);
        case (clksel)
            CKSEL_DIV_A: lim = CNT_W'(DIV_A - 1);
            CKSEL_DIV_B: lim = CNT_W'(DIV_B - 1);
            default:     lim = CNT_W'(DIV_C - 1);
        endcase
        if (use_rc) begin
            tick = run & rc_tick;
        end else begin
            tick = run & (cnt_q == lim);
        end
        if (!run || use_rc || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sar_core.sv
module sar_core #(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start_wr,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             tick,
    input  logic             cmp_in,
    input  logic             irq_clr,
    output logic             busy,
    output logic [CH_W-1:0]  mux_sel,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             irq_flag
);
    import sar_pkg::*;

    localparam int IDX_W = $clog2(RES_W);

    typedef struct packed {
        sar_phase_e       phase;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] result;
        logic [CH_W-1:0]  mux;
        logic             irq;
        logic             done;
    } core_st_t;

    localparam core_st_t ST_RST = '{phase: PH_IDLE, default: '0};

    core_st_t         st_d, st_q;
    logic [RES_W-1:0] kept;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        kept      = st_q.trial;
        if (!cmp_in) begin
            kept[st_q.idx] = 1'b0;
        end

        if (!enable) begin
            st_d.phase = PH_IDLE;
        end else begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (start_wr) begin
                        st_d.phase = PH_SETUP;
                        st_d.mux   = chan_sel;
                        st_d.trial = '0;
                    end
                end
                PH_SETUP: begin
                    if (tick) begin
                        st_d.trial            = '0;
                        st_d.trial[RES_W-1]   = 1'b1;
                        st_d.idx              = IDX_W'(RES_W - 1);
                        st_d.phase            = PH_BITS;
                    end
                end
                PH_BITS: begin
                    if (tick) begin
                        if (st_q.idx == '0) begin
                            st_d.trial  = kept;
                            st_d.result = kept;
                            st_d.phase  = PH_IDLE;
                            st_d.done   = 1'b1;
                        end else begin
                            st_d.trial                         = kept;
                            st_d.trial[st_q.idx - IDX_W'(1)]   = 1'b1;
                            st_d.idx                           = st_q.idx - IDX_W'(1);
                        end
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end

        st_d.irq = (st_q.irq & ~irq_clr) | st_d.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.phase != PH_IDLE);
    assign mux_sel  = st_q.mux;
    assign dac_code = st_q.trial;
    assign result   = st_q.result;
    assign done     = st_q.done;
    assign irq_flag = st_q.irq;

endmodule

// File: rtl/sar_pack.sv
module sar_pack #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  result,
    input  logic              right_just,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo
);
    localparam int PAD = 2 * BYTE_W - RES_W;

    logic [2*BYTE_W-1:0] word;

    always_comb begin
        if (right_just) begin
            word = {{PAD{1'b0}}, result};
        end else begin
            word = {result, {PAD{1'b0}}};
        end
        res_hi = word[2*BYTE_W-1:BYTE_W];
        res_lo = word[BYTE_W-1:0];
    end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int BYTE_W = 8,
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 8,
    parameter int DIV_C  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start_wr,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [1:0]        clksel,
    input  logic              rc_tick,
    input  logic              right_just,
    input  logic              irq_clr,
    input  logic              cmp_in,
    output logic              busy,
    output logic [CH_W-1:0]   mux_sel,
    output logic [RES_W-1:0]  dac_code,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done,
    output logic              irq_flag
);
    logic             tick;
    logic [RES_W-1:0] result;

    sar_tick_gen #(
        .DIV_A (DIV_A),
        .DIV_B (DIV_B),
        .DIV_C (DIV_C)
    ) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .clksel  (clksel),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    sar_core #(
        .RES_W (RES_W),
        .CH_W  (CH_W)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start_wr (start_wr),
        .chan_sel (chan_sel),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .irq_clr  (irq_clr),
        .busy     (busy),
        .mux_sel  (mux_sel),
        .dac_code (dac_code),
        .result   (result),
        .done     (done),
        .irq_flag (irq_flag)
    );

    sar_pack #(
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) i_pack (
        .result     (result),
        .right_just (right_just),
        .res_hi     (res_hi),
        .res_lo     (res_lo)
    );

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int BYTE_W = 8,
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 8,
    parameter int DIV_C  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start_wr,
    input logic [1:0]        clksel,
    input logic              right_just,
    input logic              irq_clr,
    input logic              busy,
    input logic [CH_W-1:0]   mux_sel,
    input logic [BYTE_W-1:0] res_hi,
    input logic [BYTE_W-1:0] res_lo,
    input logic              done,
    input logic              irq_flag
);
    localparam int PAD = 2 * BYTE_W - RES_W;

    logic [15:0] busy_cnt;
    logic [15:0] want_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 16'd1;
        end else begin
            busy_cnt <= '0;
        end
    end

    always_comb begin
        case (clksel)
            2'b00:   want_len = 16'(11 * DIV_A);
            2'b01:   want_len = 16'(11 * DIV_B);
            default: want_len = 16'(11 * DIV_C);
        endcase
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        enable && start_wr && !busy |=> busy); // R2
    AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mux_sel)); // R2
    AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        done && clksel != 2'b11 |-> busy_cnt == want_len); // R3
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && irq_flag); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_RIGHT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        right_just |-> res_hi[BYTE_W-1:BYTE_W-PAD] == '0); // R7
    AST_LEFT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        !right_just |-> res_lo[PAD-1:0] == '0); // R8
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && start_wr |=> !busy); // R9
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !enable |=> !busy && !done); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag); // R11
    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq_flag); // R11

endmodule

bind sar_adc_seq sar_adc_seq_chk #(
    .RES_W  (RES_W),
    .CH_W   (CH_W),
    .BYTE_W (BYTE_W),
    .DIV_A  (DIV_A),
    .DIV_B  (DIV_B),
    .DIV_C  (DIV_C)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start_wr   (start_wr),
    .clksel     (clksel),
    .right_just (right_just),
    .irq_clr    (irq_clr),
    .busy       (busy),
    .mux_sel    (mux_sel),
    .res_hi     (res_hi),
    .res_lo     (res_lo),
    .done       (done),
    .irq_flag   (irq_flag)
);

// File: tb/test_sar_adc_seq.sv
`timescale 1ns/1ps
module test_sar_adc_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start_wr = 1'b0;
    logic [2:0] chan_sel = 3'd0;
    logic [1:0] clksel = 2'b00;
    logic       rc_tick = 1'b0;
    logic       right_just = 1'b1;
    logic       irq_clr = 1'b0;
    logic       cmp_in;
    logic       busy;
    logic [2:0] mux_sel;
    logic [9:0] dac_code;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       done;
    logic       irq_flag;

    logic [9:0] vin [8];

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    assign cmp_in = (vin[mux_sel] >= dac_code);

    sar_adc_seq i_sar_adc_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .start_wr   (start_wr),
        .chan_sel   (chan_sel),
        .clksel     (clksel),
        .rc_tick    (rc_tick),
        .right_just (right_just),
        .irq_clr    (irq_clr),
        .cmp_in     (cmp_in),
        .busy       (busy),
        .mux_sel    (mux_sel),
        .dac_code   (dac_code),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .done       (done),
        .irq_flag   (irq_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] packed_word(input logic [9:0] v, input logic rj);
        return rj ? {6'b0, v} : {v, 6'b0};
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // Full conversion on a divided clock; checks R2, R3, R5, R6 and R7 or R8.
    task automatic run_conv(input logic [1:0] sel, input logic [2:0] ch,
                            input logic rj, input logic [9:0] v);
        int cycles;
        int exp_len;
        logic [15:0] exp_w;
        vin[ch] = v;
        @(negedge clk);
        clksel = sel; chan_sel = ch; right_just = rj; start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        cycles = 1;
        chk(busy == 1'b1 && mux_sel == ch, "R2", {busy, mux_sel}, {1'b1, ch});
        while (busy && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        exp_len = 11 * (2 << (2 * sel)) + 1;
        chk(cycles == exp_len, "R3", cycles, exp_len);
        chk(done && irq_flag, "R6", {done, irq_flag}, 3);
        exp_w = packed_word(v, rj);
        chk({res_hi, res_lo} == exp_w, rj ? "R5/R7" : "R5/R8", {res_hi, res_lo}, exp_w);
        @(negedge clk);
        chk(!done, "R6", done, 0);
        clear_irq();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cycles;
        logic [15:0] held;
        for (int i = 0; i < 8; i++) vin[i] = 10'd0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !irq_flag, "R1", {busy, done, irq_flag}, 0);
        chk(dac_code == 10'd0, "R1", dac_code, 0);
        chk({res_hi, res_lo} == 16'd0, "R1", {res_hi, res_lo}, 0);
        right_just = 1'b0;
        #0;
        @(negedge clk);
        chk({res_hi, res_lo} == 16'd0, "R1", {res_hi, res_lo}, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);

        // R5: every input level, fastest clock, alternating justification
        for (int v = 0; v < 1024; v++) begin
            run_conv(2'b00, 3'(v % 8), v[0], 10'(v));
        end

        // R3: each divided clock across all channels
        for (int s = 0; s < 3; s++) begin
            for (int c = 0; c < 8; c++) begin
                run_conv(2'(s), 3'(c), 1'(c % 2), 10'((c * 131 + s * 77 + 5) % 1024));
            end
        end

        // R4: RC clock pulses only
        vin[5] = 10'd613;
        @(negedge clk);
        clksel = 2'b11; chan_sel = 3'd5; right_just = 1'b1; start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R4", busy, 1);
        for (int k = 1; k <= 11; k++) begin
            rc_tick = 1'b1;
            @(negedge clk); rc_tick = 1'b0;
            if (k == 10) chk(busy == 1'b1, "R4", busy, 1);
            repeat (3) @(negedge clk);
            if (k == 10) chk(busy == 1'b1, "R4", busy, 1);
        end
        chk(busy == 1'b0 && irq_flag, "R4", {busy, irq_flag}, 1);
        chk({res_hi, res_lo} == 16'd613, "R4", {res_hi, res_lo}, 613);
        clear_irq();
        clksel = 2'b00;

        // R7 / R8: same stored code read back in both formats
        run_conv(2'b00, 3'd2, 1'b1, 10'h2C7);
        right_just = 1'b0;
        @(negedge clk);
        chk({res_hi, res_lo} == 16'hB1C0, "R8", {res_hi, res_lo}, 16'hB1C0);
        right_just = 1'b1;
        @(negedge clk);
        chk({res_hi, res_lo} == 16'h02C7, "R7", {res_hi, res_lo}, 16'h02C7);

        // R9: start while disabled
        enable = 1'b0;
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        chk(!busy, "R9", busy, 0);
        repeat (40) @(negedge clk);
        chk(!irq_flag && !busy, "R9", {irq_flag, busy}, 0);
        chk({res_hi, res_lo} == 16'h02C7, "R9", {res_hi, res_lo}, 16'h02C7);
        enable = 1'b1;

        // R10: abort mid-conversion
        vin[1] = 10'd77;
        @(negedge clk); chan_sel = 3'd1; clksel = 2'b01; start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        repeat (40) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R10", {busy, done}, 0);
        repeat (400) @(negedge clk);
        chk(!irq_flag, "R10", irq_flag, 0);
        chk({res_hi, res_lo} == 16'h02C7, "R10", {res_hi, res_lo}, 16'h02C7);
        enable = 1'b1;
        run_conv(2'b00, 3'd1, 1'b1, 10'd77);

        // R2 / R12: channel change and repeated start during conversion
        vin[6] = 10'd900; vin[3] = 10'd12;
        @(negedge clk); clksel = 2'b01; chan_sel = 3'd6; start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0; cycles = 1;
        chan_sel = 3'd3;
        repeat (19) begin @(negedge clk); cycles++; end
        chk(mux_sel == 3'd6, "R2", mux_sel, 6);
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0; cycles++;
        while (busy && cycles < 2000) begin @(negedge clk); cycles++; end
        chk(cycles == 89, "R12", cycles, 89);
        chk({res_hi, res_lo} == 16'd900, "R12", {res_hi, res_lo}, 900);

        // R11: flag holds, then clear coinciding with completion
        repeat (30) @(negedge clk);
        chk(irq_flag, "R11", irq_flag, 1);
        clksel = 2'b00; chan_sel = 3'd0; vin[0] = 10'd345;
        start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        repeat (21) @(negedge clk);
        chk(busy, "R11", busy, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        chk(!busy && irq_flag && done, "R11", {busy, irq_flag, done}, 3);
        @(negedge clk);
        irq_clr = 1'b0;
        chk(!irq_flag, "R11", irq_flag, 0);
        held = {res_hi, res_lo};
        chk(held == 16'd345, "R11", held, 345);

        finish_run();
    end

endmodule